// File: doc/BRIEF.md
# Stop Recovery Sequencer with Clock-Failure Monitor

This block decides when the processor core may run again after a low-power halt. It also watches the system E clock for loss or severe slowdown. A halt request drops the core's run permission. A later wake event starts a settle period whose length depends on a software-selectable delay bit. The long setting waits 4064 E cycles so the oscillator can stabilise. The short setting resumes the core after two E cycles.

A second, slower and independent reference clock supervises the E clock. At every reference edge, the block compares how far a Gray-coded E-cycle tally has advanced since the previous edge. When monitoring is enabled and the advance is below a minimum, the block raises a clock-failure reset request. That request is timed entirely on the reference clock, so it still appears when E has stopped. Software must clear the monitor enable before halting, because halting stops E, and set it again after recovery. Both control bits come out of reset set.

Top module: `stop_clk_guard`

## Requirements
- R1: After reset, run_en is 1, cfg_dly is 1, cfg_cme is 1 and clk_fail_rst is 0.
- R2: While running, stop_req sampled high on an E rising edge drops run_en after that edge. run_en stays low while halted with no wake, even if stop_req is repeated.
- R3: With the delay bit at 1 when wake is sampled in the halted state, run_en rises on the 4064th E rising edge after the edge that sampled wake.
- R4: With the delay bit at 0 when wake is sampled, run_en rises on the 2nd E rising edge after the edge that sampled wake.
- R5: The settle length is fixed by the delay bit at the wake edge. A write to the delay bit, or a stop_req, during settling does not change the current settle length.
- R6: The settle counter restarts from zero on every halt entry, so repeated halt/wake rounds give identical settle lengths. wake while running has no effect on run_en.
- R7: With cfg_cme at 0, clk_fail_rst stays 0 for any E rate, including a stopped E clock.
- R8: With cfg_cme at 1, clk_fail_rst stays 0 while E advances at least 2 cycles per reference period. It asserts when E advances fewer, including when E is stopped.
- R9: Each clk_fail_rst pulse is high for exactly 4 consecutive reference periods, and it is produced with E stopped.
- R10: ctl_we high on an E rising edge loads ctl_dly into cfg_dly and ctl_cme into cfg_cme, visible after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| e_clk | input | 1 | Monitored system E clock; clocks the sequencer |
| ref_clk | input | 1 | Slow independent reference clock for the monitor |
| rst_n | input | 1 | Asynchronous active-low reset, released per clock domain |
| stop_req | input | 1 | Request to enter the halted state |
| wake | input | 1 | Wake event ending the halt |
| ctl_we | input | 1 | Write strobe for the two control bits |
| ctl_dly | input | 1 | New value of the long-settle select bit |
| ctl_cme | input | 1 | New value of the clock-monitor enable bit |
| run_en | output | 1 | Core may execute when high |
| cfg_dly | output | 1 | Current long-settle select bit |
| cfg_cme | output | 1 | Current clock-monitor enable bit |
| clk_fail_rst | output | 1 | Clock-failure reset request (reference domain) |

## Verification
The hardest situation to reach from the ports is a failure pulse while E is frozen. In that state nothing on the E side can react, and the evidence must come only from reference-clock sampling. The bench gates its own E generator to hold the clock at a fixed level, and it also slows E to a fraction of the reference rate. It sweeps the monitor enable against four E rates and measures pulse widths only for pulses that start inside the observation window. The settle path is swept over both delay settings and repeated rounds, with mid-settle writes and stop requests.

// File: rtl/stop_clk_pkg.sv
package stop_clk_pkg;
  typedef enum logic [1:0] {
    PH_RUN    = 2'd0,
    PH_HALT   = 2'd1,
    PH_SETTLE = 2'd2
  } phase_t;
endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] pipe_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pipe_q <= 2'b00;
    end else begin
      pipe_q <= {pipe_q[0], 1'b1};
    end
  end

  assign srst_n = pipe_q[1];
endmodule

// File: rtl/sync_bits.sv
module sync_bits #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/edge_tally.sv
module edge_tally #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] gray
);
  logic [W-1:0] bin_q, bin_d;
  logic [W-1:0] gray_q, gray_d;

  always_comb begin
    bin_d  = bin_q + W'(1);
    gray_d = bin_d ^ (bin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  assign gray = gray_q;

  // successive Gray values differ in exactly one bit
  AST_GRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $countones(gray_q ^ $past(gray_q)) <= 1); // R8
endmodule

// File: rtl/clk_watch.sv
module clk_watch #(
  parameter int W          = 6,
  parameter int MIN_EDGES  = 2,
  parameter int HOLD_TICKS = 4
) (
  input  logic         ref_clk,
  input  logic         rst_n,
  input  logic [W-1:0] e_gray,
  input  logic         cme,
  output logic         fail_rst
);
  localparam int HW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;

  logic [W-1:0]  gray_s;
  logic          cme_s;
  logic [W-1:0]  cur_bin;
  logic [W-1:0]  prev_q, prev_d;
  logic [W-1:0]  delta;
  logic          slow;
  logic          fail_q, fail_d;
  logic [HW-1:0] hold_q, hold_d;

  sync_bits #(.W(W)) u_gsync (
    .clk(ref_clk), .rst_n(rst_n), .d(e_gray), .q(gray_s)
  );

  sync_bits #(.W(1)) u_csync (
    .clk(ref_clk), .rst_n(rst_n), .d(cme), .q(cme_s)
  );

  always_comb begin
    cur_bin[W-1] = gray_s[W-1];
    for (int i = W - 2; i >= 0; i--) begin
      cur_bin[i] = cur_bin[i+1] ^ gray_s[i];
    end
  end

  assign delta = cur_bin - prev_q;
  assign slow  = (delta < W'(MIN_EDGES));

  always_comb begin
    prev_d = cur_bin;
    fail_d = fail_q;
    hold_d = hold_q;
    if (fail_q) begin
      if (hold_q == HW'(HOLD_TICKS - 1)) begin
        fail_d = 1'b0;
        hold_d = '0;
      end else begin
        hold_d = hold_q + HW'(1);
      end
    end else if (cme_s && slow) begin
      fail_d = 1'b1;
      hold_d = '0;
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      fail_q <= 1'b0;
      hold_q <= '0;
    end else begin
      prev_q <= prev_d;
      fail_q <= fail_d;
      hold_q <= hold_d;
    end
  end

  assign fail_rst = fail_q;

  AST_FAIL_NEEDS_ENABLE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(fail_q) |-> $past(cme_s)); // R7
  AST_FAIL_HAS_CAUSE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(fail_q) |-> $past(delta) < W'(MIN_EDGES)); // R8
  AST_PULSE_HELD: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (fail_q && hold_q != HW'(HOLD_TICKS - 1)) |=> fail_q); // R9
endmodule

// File: rtl/stop_seq.sv
module stop_seq
  import stop_clk_pkg::*;
#(
  parameter int DLY_CYC  = 4064,
  parameter int FAST_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic wake,
  input  logic ctl_we,
  input  logic ctl_dly,
  input  logic ctl_cme,
  output logic run_en,
  output logic dly_bit,
  output logic cme_bit
);
  localparam int CW = $clog2(DLY_CYC + 1);

  phase_t        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim_q, lim_d;
  logic          dly_q, cme_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= 1'b1;
      cme_q <= 1'b1;
    end else if (ctl_we) begin
      dly_q <= ctl_dly;
      cme_q <= ctl_cme;
    end
  end

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    lim_d = lim_q;
    case (ph_q)
      PH_RUN: begin
        cnt_d = '0;
        if (stop_req) ph_d = PH_HALT;
      end
      PH_HALT: begin
        cnt_d = '0;
        if (wake) begin
          ph_d  = PH_SETTLE;
          lim_d = dly_q ? CW'(DLY_CYC) : CW'(FAST_CYC);
        end
      end
      PH_SETTLE: begin
        if (cnt_q == lim_q - CW'(1)) begin
          ph_d  = PH_RUN;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: begin
        ph_d  = PH_RUN;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_RUN;
      cnt_q <= '0;
      lim_q <= CW'(DLY_CYC);
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end

  assign run_en  = (ph_q == PH_RUN);
  assign dly_bit = dly_q;
  assign cme_bit = cme_q;

  AST_STOP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && stop_req) |=> !run_en); // R2
  AST_HALT_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_HALT) |-> cnt_q == '0); // R6
  AST_RISE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |-> $past(cnt_q) == $past(lim_q) - CW'(1)); // R3
  AST_LIMIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SETTLE && $past(ph_q) == PH_SETTLE) |-> $stable(lim_q)); // R5
endmodule

// File: rtl/stop_clk_guard.sv
module stop_clk_guard #(
  parameter int DLY_CYC    = 4064,
  parameter int FAST_CYC   = 2,
  parameter int TALLY_W    = 6,
  parameter int MIN_EDGES  = 2,
  parameter int HOLD_TICKS = 4
) (
  input  logic e_clk,
  input  logic ref_clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic wake,
  input  logic ctl_we,
  input  logic ctl_dly,
  input  logic ctl_cme,
  output logic run_en,
  output logic cfg_dly,
  output logic cfg_cme,
  output logic clk_fail_rst
);
  logic e_rst_n;
  logic r_rst_n;
  logic [TALLY_W-1:0] e_gray;

  rst_sync u_rs_e (.clk(e_clk),   .arst_n(rst_n), .srst_n(e_rst_n));
  rst_sync u_rs_r (.clk(ref_clk), .arst_n(rst_n), .srst_n(r_rst_n));

  stop_seq #(.DLY_CYC(DLY_CYC), .FAST_CYC(FAST_CYC)) u_seq (
    .clk(e_clk), .rst_n(e_rst_n), .stop_req(stop_req), .wake(wake),
    .ctl_we(ctl_we), .ctl_dly(ctl_dly), .ctl_cme(ctl_cme),
    .run_en(run_en), .dly_bit(cfg_dly), .cme_bit(cfg_cme)
  );

  edge_tally #(.W(TALLY_W)) u_tally (
    .clk(e_clk), .rst_n(e_rst_n), .gray(e_gray)
  );

  clk_watch #(.W(TALLY_W), .MIN_EDGES(MIN_EDGES), .HOLD_TICKS(HOLD_TICKS)) u_watch (
    .ref_clk(ref_clk), .rst_n(r_rst_n), .e_gray(e_gray), .cme(cfg_cme),
    .fail_rst(clk_fail_rst)
  );
endmodule

// File: tb/sim_stop_clk_guard.sv
`timescale 1ns/100ps
module sim_stop_clk_guard;
  logic e_clk = 1'b0;
  logic ref_clk = 1'b0;
  logic rst_n, stop_req, wake, ctl_we, ctl_dly, ctl_cme;
  logic run_en, cfg_dly, cfg_cme, clk_fail_rst;
  logic e_run = 1'b1;
  real  e_half = 2.5;
  int   total = 0;
  int   bad = 0;

  stop_clk_guard u0 (
    .e_clk(e_clk), .ref_clk(ref_clk), .rst_n(rst_n), .stop_req(stop_req),
    .wake(wake), .ctl_we(ctl_we), .ctl_dly(ctl_dly), .ctl_cme(ctl_cme),
    .run_en(run_en), .cfg_dly(cfg_dly), .cfg_cme(cfg_cme),
    .clk_fail_rst(clk_fail_rst)
  );

  always begin
    #(e_half);
    if (e_run) e_clk = ~e_clk;
  end

  always #40 ref_clk = ~ref_clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic e_step();
    @(posedge e_clk);
    #1;
  endtask

  task automatic r_step();
    @(negedge ref_clk);
  endtask

  task automatic wr_ctl(input bit d, input bit c);
    ctl_dly = d; ctl_cme = c; ctl_we = 1'b1;
    e_step();
    ctl_we = 1'b0;
    chk(cfg_dly == d, "R10 dly write", int'(cfg_dly), int'(d));
    chk(cfg_cme == c, "R10 cme write", int'(cfg_cme), int'(c));
  endtask

  // halt, then wake; mid: 1 = write new dly and pulse stop_req on the first settle edge
  task automatic halt_wake(input bit mid, input bit mid_dly, output int n);
    stop_req = 1'b1;
    e_step();
    stop_req = 1'b0;
    chk(!run_en, "R2 halt entry", int'(run_en), 0);
    for (int i = 0; i < 3; i++) begin
      stop_req = (i == 1);
      e_step();
    end
    stop_req = 1'b0;
    chk(!run_en, "R2 halted without wake", int'(run_en), 0);
    wake = 1'b1;
    e_step();
    wake = 1'b0;
    n = 0;
    if (mid) begin
      ctl_dly = mid_dly; ctl_cme = cfg_cme; ctl_we = 1'b1; stop_req = 1'b1;
      e_step();
      ctl_we = 1'b0; stop_req = 1'b0;
      n = 1;
    end
    while (!run_en && n < 5000) begin
      e_step();
      n++;
    end
  endtask

  // count high samples and the width of the first pulse that starts in the window
  task automatic observe(input int ticks, output int highs, output int width);
    bit prev, counting;
    int len;
    highs = 0; width = 0; counting = 1'b0; len = 0;
    prev = clk_fail_rst;
    for (int t = 0; t < ticks; t++) begin
      r_step();
      if (clk_fail_rst) highs++;
      if (clk_fail_rst && !prev && width == 0) begin counting = 1'b1; len = 1; end
      else if (clk_fail_rst && counting) len++;
      else if (!clk_fail_rst && counting) begin width = len; counting = 1'b0; end
      prev = clk_fail_rst;
    end
  endtask

  initial begin
    #900000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, n0, hi, w;
    real per[4];
    per[0] = 2.5; per[1] = 5.0; per[2] = 10.0; per[3] = 100.0;
    rst_n = 1'b0; stop_req = 1'b0; wake = 1'b0;
    ctl_we = 1'b0; ctl_dly = 1'b0; ctl_cme = 1'b0;
    #200;
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) e_step();
    r_step(); r_step(); r_step();
    chk(run_en == 1'b1, "R1 run_en", int'(run_en), 1);
    chk(cfg_dly == 1'b1, "R1 cfg_dly", int'(cfg_dly), 1);
    chk(cfg_cme == 1'b1, "R1 cfg_cme", int'(cfg_cme), 1);
    chk(clk_fail_rst == 1'b0, "R1 clk_fail_rst", int'(clk_fail_rst), 0);

    // R6: wake while running does nothing
    wake = 1'b1;
    e_step(); e_step();
    wake = 1'b0;
    for (int i = 0; i < 4; i++) begin
      e_step();
      chk(run_en == 1'b1, "R6 wake ignored while running", int'(run_en), 1);
    end

    // R3/R4/R6: sweep delay bit over repeated rounds (reset value of dly first)
    halt_wake(1'b0, 1'b0, n);
    chk(n == 4064, "R3 long settle at reset dly", n, 4064);
    for (int rep = 0; rep < 2; rep++) begin
      for (int d = 0; d < 2; d++) begin
        wr_ctl(d[0], 1'b0);
        halt_wake(1'b0, 1'b0, n);
        chk(n == (d ? 4064 : 2), d ? "R3 long settle" : "R4 short settle", n, d ? 4064 : 2);
        if (rep == 0 && d == 0) n0 = n;
        if (rep == 1 && d == 0) chk(n == n0, "R6 repeat round", n, n0);
      end
    end

    // R5: mid-settle writes and stop_req do not alter the active settle
    wr_ctl(1'b0, 1'b0);
    halt_wake(1'b1, 1'b1, n);
    chk(n == 2, "R5 short settle kept", n, 2);
    chk(cfg_dly == 1'b1, "R10 dly after mid write", int'(cfg_dly), 1);
    halt_wake(1'b1, 1'b0, n);
    chk(n == 4064, "R5 long settle kept", n, 4064);

    // R7/R8/R9: monitor enable against E rates, plus a stopped E
    for (int c = 0; c < 2; c++) begin
      for (int p = 0; p < 5; p++) begin
        bit expect_fail;
        e_half = 2.5; e_run = 1'b1;
        r_step();
        wr_ctl(1'b1, c[0]);
        observe(12, hi, w);
        if (p < 4) e_half = per[p];
        else e_run = 1'b0;
        r_step(); r_step(); r_step();
        observe(24, hi, w);
        expect_fail = c[0] && (p >= 3);
        if (c == 0)
          chk(hi == 0, "R7 no fail when disabled", hi, 0);
        else
          chk((hi != 0) == expect_fail, "R8 fail detection", int'(hi != 0), int'(expect_fail));
        if (expect_fail)
          chk(w == 4, "R9 pulse width", w, 4);
      end
    end
    e_half = 2.5; e_run = 1'b1;
    observe(12, hi, w);
    observe(20, hi, w);
    chk(hi == 0, "R8 recovered clock quiet", hi, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule